// File: doc/BRIEF.md
# Two-Stage Cascaded Noise Shaper for a Frequency Discriminator

This block follows a first-order digital frequency discriminator and raises the order of its noise shaping to two. The discriminator produces two signals on every reference event: a one-bit decision and its internal phase error, held as a signed binary word. This block feeds that error word into a second, purely digital first-order modulator. It then merges the two one-bit decisions into a single small signed word. In that word the coarse quantization error of the discriminator is cancelled to first order and replaced by a second-order-shaped residue.

The merge is pure arithmetic on registered values and is clocked by the same strobe as the discriminator. The two paths therefore cannot drift apart in time. A decimator or loop filter downstream takes the output word once per strobe, when the valid flag is high.

Top module: `mash11_shaper`

## Requirements
- R1: While reset is held, and after reset until the first strobe, `y_vld` is 0 and `y_out` is 0.
- R2: `y_vld` is high for exactly the one clock cycle after each cycle in which `ref_stb` is high, and low at all other times.
- R3: When `ref_stb` is low, `st1_bit` and `st1_err` have no effect. The second-stage accumulator and the one-strobe delay keep their values, and the next strobe's output shows this.
- R4: On each strobe the second stage forms v = A + E, where A is its accumulator and E is `st1_err` taken as two's complement. Its bit q2 is 1 when v >= 0 and 0 when v < 0. The new A is v - H when q2 = 1 and v + H when q2 = 0, with H = 2^(ERR_W-2).
- R5: The output word is y = b1 + q2 - q2_prev. Here b1 is `st1_bit` (0 or 1) and q2_prev is q2 from the previous strobe. y is coded as 3-bit two's complement and always lies in -1..2.
- R6: For any |E| <= H, the second-stage accumulator stays within [-2H, 2H).
- R7: After any number of strobes, the sum of all y minus the sum of all b1 is 0 or 1. This makes the long-run mean of y equal to the mean of b1.
- R8: Reset clears the accumulator and q2_prev to 0. The first output after reset is therefore b1 + q2.
- R9: `y_out` holds its value in every cycle except the one after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | 1 | One-cycle reference event strobe |
| st1_bit | input | 1 | First-stage one-bit decision |
| st1_err | input | ERR_W | First-stage phase error, signed |
| y_out | output | 3 | Combined shaped output, signed |
| y_vld | output | 1 | Output valid, one cycle per strobe |

## Verification
A wrong accumulator value or a lost update changes q2. Because y subtracts q2_prev, that fault appears twice: once in the output of the faulty strobe and once, with opposite sign, in the output of the next strobe. A scoreboard model therefore sees it within one strobe. A delay register that is not cleared, or one that is updated without a strobe, breaks the bound on the running sum of y minus b1 at the next output. A skewed strobe path shows as a valid flag in the wrong cycle.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int Y_W = 3;
  typedef logic signed [Y_W-1:0] y_t;

  // Error-cancelling merge: first-stage bit plus first difference of second-stage bit
  function automatic y_t merge_y(input logic b1, input logic q2, input logic q2_prev);
    y_t s;
    s = y_t'({2'b00, b1}) + y_t'({2'b00, q2}) - y_t'({2'b00, q2_prev});
    return s;
  endfunction
endpackage

// File: rtl/mash_stage2.sv
module mash_stage2 #(
  parameter int ERR_W = 8,
  parameter int ACC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [ERR_W-1:0] err,
  output logic             q_bit
);
  localparam int VW   = ACC_W + 1;
  localparam int HALF = 2 ** (ERR_W - 2);
  localparam int LIM  = 2 * HALF;
  localparam logic signed [VW-1:0] HALF_V = VW'(HALF);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [VW-1:0]    sum_v;
  logic signed [VW-1:0]    nxt_v;

  function automatic logic signed [VW-1:0] widen_err(input logic [ERR_W-1:0] e);
    return {{(VW-ERR_W){e[ERR_W-1]}}, e};
  endfunction

  always_comb begin
    sum_v = {acc_q[ACC_W-1], acc_q} + widen_err(err);
    q_bit = ~sum_v[VW-1];
    nxt_v = q_bit ? (sum_v - HALF_V) : (sum_v + HALF_V);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (stb) acc_q <= nxt_v[ACC_W-1:0];
  end

  assert_acc_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc_q) >= -LIM) && (int'(acc_q) < LIM));

  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(acc_q));
endmodule

// File: rtl/mash_combiner.sv
module mash_combiner
  import mash_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic b1,
  input  logic q2,
  output y_t   y_out,
  output logic y_vld
);
  logic q2_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q2_prev <= 1'b0;
      y_out   <= '0;
      y_vld   <= 1'b0;
    end else begin
      y_vld <= stb;
      if (stb) begin
        q2_prev <= q2;
        y_out   <= merge_y(b1, q2, q2_prev);
      end
    end
  end

  assert_vld_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> y_vld);
  assert_no_vld_without_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> !y_vld);
  assert_out_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |-> (y_out >= -3'sd1) && (y_out <= 3'sd2));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(y_out));
endmodule

// File: rtl/mash11_shaper.sv
module mash11_shaper #(
  parameter int ERR_W = 8,
  parameter int ACC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_stb,
  input  logic             st1_bit,
  input  logic [ERR_W-1:0] st1_err,
  output logic [2:0]       y_out,
  output logic             y_vld
);
  logic q2_bit;
  mash_pkg::y_t y_w;

  mash_stage2 #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_st2 (
    .clk(clk), .rst_n(rst_n), .stb(ref_stb), .err(st1_err), .q_bit(q2_bit)
  );

  mash_combiner u_cmb (
    .clk(clk), .rst_n(rst_n), .stb(ref_stb), .b1(st1_bit), .q2(q2_bit),
    .y_out(y_w), .y_vld(y_vld)
  );

  assign y_out = y_w;
endmodule

// File: tb/sim_mash11_shaper.sv
module sim_mash11_shaper;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 8;
  localparam int H = 2 ** (ERR_W - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_stb = 1'b0;
  logic st1_bit = 1'b0;
  logic [ERR_W-1:0] st1_err = '0;
  logic [2:0] y_out;
  logic y_vld;

  int checks = 0;
  int failures = 0;
  int exp_q[$];
  int b1_q[$];
  int m_acc = 0;
  int m_q2p = 0;
  int sum_y = 0;
  int sum_b1 = 0;
  int last_y = 0;
  int strobes = 0;
  int vlds = 0;
  bit done = 1'b0;

  mash11_shaper #(.ERR_W(ERR_W), .ACC_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .st1_bit(st1_bit),
    .st1_err(st1_err), .y_out(y_out), .y_vld(y_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx3(input logic [2:0] v);
    return v[2] ? int'(v) - 8 : int'(v);
  endfunction

  // Bench model of R4/R5: restated from the requirements
  task automatic strobe(input bit b, input int e, input int idle);
    int v;
    int q2;
    @(negedge clk);
    st1_bit = b;
    st1_err = ERR_W'(e);
    ref_stb = 1'b1;
    v = m_acc + e;
    q2 = (v >= 0) ? 1 : 0;
    m_acc = q2 ? v - H : v + H;
    exp_q.push_back(int'(b) + q2 - m_q2p);
    b1_q.push_back(int'(b));
    m_q2p = q2;
    strobes++;
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      ref_stb = 1'b0;
      st1_bit = ~st1_bit;          // R3: junk while no strobe
      st1_err = ERR_W'(-e + 17 * i);
    end
    if (idle == 0) begin
      @(negedge clk);
      ref_stb = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    ref_stb = 1'b0;
    rst_n = 1'b0;
    m_acc = 0;
    m_q2p = 0;
    sum_y = 0;
    sum_b1 = 0;
    last_y = 0;
    repeat (3) @(negedge clk);
    chk(y_vld == 1'b0, "R1 vld in reset", int'(y_vld), 0);
    chk(y_out == 3'd0, "R1 y in reset", sx3(y_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(y_vld == 1'b0, "R1 vld after reset", int'(y_vld), 0);
    chk(y_out == 3'd0, "R1 y after reset", sx3(y_out), 0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (y_vld) begin
        vlds++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected valid", 1, 0);
        end else begin
          int e;
          int b;
          e = exp_q.pop_front();
          b = b1_q.pop_front();
          chk(sx3(y_out) == e, "R4 R5 y value", sx3(y_out), e);
          chk(sx3(y_out) >= -1 && sx3(y_out) <= 2, "R5 range", sx3(y_out), 0);
          sum_y += sx3(y_out);
          sum_b1 += b;
          chk((sum_y - sum_b1) == 0 || (sum_y - sum_b1) == 1, "R7 running sum",
              sum_y - sum_b1, 0);
          last_y = sx3(y_out);
        end
      end else begin
        chk(sx3(y_out) == last_y, "R9 hold", sx3(y_out), last_y);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R8: first output after reset: q2_prev is 0 -> y = b1 + q2 = 0 + 1
    strobe(1'b0, 10, 2);
    // constant error, the mean check of R7
    for (int i = 0; i < 200; i++) strobe((i % 3) == 0, 20, i % 3);
    for (int i = 0; i < 150; i++) strobe((i % 4) != 0, -30, 1);
    for (int i = 0; i < 100; i++) strobe(i[0], 0, 0);
    // bounds of R6
    for (int i = 0; i < 60; i++) strobe(1'b1, H, 0);
    for (int i = 0; i < 60; i++) strobe(1'b0, -H, 1);
    for (int i = 0; i < 80; i++) strobe(i[1], (i[0] ? H : -H), 0);
    // R3: long idle gaps with junk inputs
    for (int i = 0; i < 20; i++) strobe(1'b1, 7, 9);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all strobes answered", exp_q.size(), 0);
    // R8: drive q2_prev to 1, then reset; first output must not subtract it
    strobe(1'b0, 50, 1);
    repeat (2) @(negedge clk);
    do_reset();
    strobe(1'b0, 5, 2);
    repeat (3) @(negedge clk);
    chk(last_y == 1, "R8 first output after reset", last_y, 1);
    chk(vlds == strobes, "R2 valid count", vlds, strobes);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule